// File: doc/BRIEF.md
# Debug Exception Event Collector

This block sits at the instruction boundary of a small in-order core and turns a set of per-instruction debug conditions into at most two exception requests and a sticky status word. Each time the pipeline presents a boundary strobe, the block looks at the conditions that belong to that boundary. Some conditions are faults, meaning they are reported before the matching instruction runs. The others are traps, meaning they are reported after the instruction that caused them has completed. It raises a one-cycle fault pulse, a one-cycle trap pulse, or both, and ORs the matching cause bits into the status word.

Instruction-address matches are faults and are masked by the restart flag. A debug-register access while an external emulator owns those registers is also a fault. Data-address matches, the trace (single-step) flag and a switch into a traced task are traps. Data matches only request a trap when at least one exact-match enable is set. The same enables make the block hold off the next instruction while data transfers are still outstanding. A pending external interrupt yields to any debug request at the same boundary and is taken at a later boundary.

Top module: `dbg_event_collector`

## Requirements
- R1: One cycle after a boundary strobe with an instruction-address hit in any slot and the restart flag low, `fault_req_o` is high for exactly one cycle and the status bit of each hit slot (bit n = slot n) is set. No fault pulse appears in a cycle that does not follow a boundary strobe.
- R2: With the restart flag high at a boundary, instruction-address hits raise no fault and set no status bit. Data hits, the trace flag and protected-access faults at that boundary are handled as usual.
- R3: A debug-register access at a boundary while the emulator owns the registers produces a fault pulse one cycle later and sets `stat_prot_o`.
- R4: A data-address hit at a boundary with at least one of the two exact-match enable bits set produces a trap pulse one cycle later and sets the status bit of each hit slot.
- R5: A data-address hit at a boundary with both exact-match enable bits clear sets the slot's status bit but requests no trap.
- R6: The trace flag high at a boundary produces a trap pulse one cycle later and sets `stat_step_o`.
- R7: A completed switch into a traced task, flagged at a boundary, produces a trap pulse one cycle later and sets `stat_task_o`.
- R8: Fault and trap conditions at the same boundary give both pulses in the same cycle, and every matching status bit is set together.
- R9: Status bits are sticky, and new events OR into them. The clear strobe zeroes them one cycle later. When a clear and a boundary fall in the same cycle, the status afterwards holds only that boundary's events.
- R10: `stall_o` is high, combinationally, exactly when data transfers are outstanding and at least one exact-match enable bit is set.
- R11: `irq_take_o` pulses one cycle after a boundary at which the external interrupt is pending and no fault or trap is requested. If a debug request is present at that boundary there is no pulse, and the interrupt is taken at a later boundary if it is still pending.
- R12: During and right after synchronous reset, all requests, the stall output's registered peers and all status bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd_valid_i | input | 1 | Instruction boundary strobe; conditions below are sampled with it |
| ia_hit_i | input | N_SLOTS | Instruction-address match per slot |
| da_hit_i | input | N_SLOTS | Data-address match per slot for the completing instruction |
| exact_en_i | input | 2 | Exact-match enable bits (either one enables exact reporting) |
| data_busy_i | input | 1 | Data transfers of the previous instruction still outstanding |
| trace_i | input | 1 | Trace flag as sampled at the start of the completing instruction |
| task_trace_i | input | 1 | Switch into a task with its trace bit set has just completed |
| dreg_access_i | input | 1 | Attempt to access the debug registers |
| emu_own_i | input | 1 | External emulator owns the debug registers |
| restart_i | input | 1 | Restart flag; masks instruction-address faults |
| ext_irq_i | input | 1 | External interrupt pending |
| stat_clr_i | input | 1 | Write-zero strobe clearing the status word |
| fault_req_o | output | 1 | One-cycle fault-class debug exception request |
| trap_req_o | output | 1 | One-cycle trap-class debug exception request |
| stat_hit_o | output | N_SLOTS | Sticky per-slot breakpoint status |
| stat_step_o | output | 1 | Sticky single-step status |
| stat_prot_o | output | 1 | Sticky protected-access status |
| stat_task_o | output | 1 | Sticky task-switch status |
| stall_o | output | 1 | Hold the next instruction for exact data reporting |
| irq_take_o | output | 1 | One-cycle pulse: take the external interrupt now |

## Verification
The bench builds the block with the default of four breakpoint slots. This lets it drive every slot alone, in combination, and all at once, and check that the per-slot status bits stay apart. A behavioural model is compared on every clock under directed sequences and a long biased-random run. That run mixes restart-masked hits, inexact data hits, clears that land on boundaries, and interrupts that collide with single-step traps.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;

    localparam int DEF_SLOTS = 4;
    localparam int EXACT_W   = 2;

    // Non-slot cause flags recorded in the status word
    typedef struct packed {
        logic step;
        logic prot;
        logic tsw;
    } dbg_flags_t;

    // Debug request pair produced at one boundary
    typedef struct packed {
        logic fault;
        logic trap;
    } dbg_req_t;

    function automatic logic exact_on(input logic [EXACT_W-1:0] en);
        return |en;
    endfunction

endpackage

// File: rtl/dbg_fault_unit.sv
module dbg_fault_unit #(
    parameter int N_SLOTS = dbg_evt_pkg::DEF_SLOTS
) (
    input  logic               bnd_i,
    input  logic [N_SLOTS-1:0] ia_hit_i,
    input  logic               restart_i,
    input  logic               dreg_access_i,
    input  logic               emu_own_i,
    output logic [N_SLOTS-1:0] ia_rec_o,
    output logic               prot_o,
    output logic               fault_o
);
    always_comb begin
        ia_rec_o = '0;
        if (bnd_i && !restart_i) ia_rec_o = ia_hit_i;
        prot_o  = bnd_i && dreg_access_i && emu_own_i;
        fault_o = (|ia_rec_o) || prot_o;
    end
endmodule

// File: rtl/dbg_trap_unit.sv
module dbg_trap_unit #(
    parameter int N_SLOTS = dbg_evt_pkg::DEF_SLOTS
) (
    input  logic                             bnd_i,
    input  logic [N_SLOTS-1:0]               da_hit_i,
    input  logic [dbg_evt_pkg::EXACT_W-1:0]  exact_en_i,
    input  logic                             trace_i,
    input  logic                             task_trace_i,
    output logic [N_SLOTS-1:0]               da_rec_o,
    output logic                             step_o,
    output logic                             tsw_o,
    output logic                             trap_o
);
    logic data_cause;

    always_comb begin
        da_rec_o   = bnd_i ? da_hit_i : '0;
        data_cause = (|da_rec_o) && dbg_evt_pkg::exact_on(exact_en_i);
        step_o     = bnd_i && trace_i;
        tsw_o      = bnd_i && task_trace_i;
        trap_o     = data_cause || step_o || tsw_o;
    end
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg #(
    parameter int N_SLOTS = dbg_evt_pkg::DEF_SLOTS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr_i,
    input  logic [N_SLOTS-1:0]      new_hit_i,
    input  dbg_evt_pkg::dbg_flags_t new_flags_i,
    output logic [N_SLOTS-1:0]      hit_o,
    output dbg_evt_pkg::dbg_flags_t flags_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o   <= '0;
            flags_o <= '0;
        end else begin
            hit_o   <= (clr_i ? '0 : hit_o) | new_hit_i;
            flags_o <= (clr_i ? '0 : flags_o) | new_flags_i;
        end
    end

    // R9: no clear and no new event -> status holds
    assert_status_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && new_hit_i == '0 && new_flags_i == '0) |=> ($stable(hit_o) && $stable(flags_o)));

    // R9: after a clear only the same-cycle events remain
    assert_clear_leaves_new_R9: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (hit_o == $past(new_hit_i) && flags_o == $past(new_flags_i)));
endmodule

// File: rtl/dbg_event_collector.sv
module dbg_event_collector #(
    parameter int N_SLOTS = dbg_evt_pkg::DEF_SLOTS
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            bnd_valid_i,
    input  logic [N_SLOTS-1:0]              ia_hit_i,
    input  logic [N_SLOTS-1:0]              da_hit_i,
    input  logic [dbg_evt_pkg::EXACT_W-1:0] exact_en_i,
    input  logic                            data_busy_i,
    input  logic                            trace_i,
    input  logic                            task_trace_i,
    input  logic                            dreg_access_i,
    input  logic                            emu_own_i,
    input  logic                            restart_i,
    input  logic                            ext_irq_i,
    input  logic                            stat_clr_i,
    output logic                            fault_req_o,
    output logic                            trap_req_o,
    output logic [N_SLOTS-1:0]              stat_hit_o,
    output logic                            stat_step_o,
    output logic                            stat_prot_o,
    output logic                            stat_task_o,
    output logic                            stall_o,
    output logic                            irq_take_o
);
    import dbg_evt_pkg::*;

    logic [N_SLOTS-1:0] ia_rec, da_rec;
    logic               prot_ev, step_ev, tsw_ev;
    dbg_req_t           req_d, req_q;
    dbg_flags_t         new_flags, cur_flags;
    logic               irq_d, irq_q;

    dbg_fault_unit #(.N_SLOTS(N_SLOTS)) u_fault (
        .bnd_i         (bnd_valid_i),
        .ia_hit_i      (ia_hit_i),
        .restart_i     (restart_i),
        .dreg_access_i (dreg_access_i),
        .emu_own_i     (emu_own_i),
        .ia_rec_o      (ia_rec),
        .prot_o        (prot_ev),
        .fault_o       (req_d.fault)
    );

    dbg_trap_unit #(.N_SLOTS(N_SLOTS)) u_trap (
        .bnd_i        (bnd_valid_i),
        .da_hit_i     (da_hit_i),
        .exact_en_i   (exact_en_i),
        .trace_i      (trace_i),
        .task_trace_i (task_trace_i),
        .da_rec_o     (da_rec),
        .step_o       (step_ev),
        .tsw_o        (tsw_ev),
        .trap_o       (req_d.trap)
    );

    always_comb begin
        new_flags.step = step_ev;
        new_flags.prot = prot_ev;
        new_flags.tsw  = tsw_ev;
    end

    dbg_status_reg #(.N_SLOTS(N_SLOTS)) u_status (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (stat_clr_i),
        .new_hit_i   (ia_rec | da_rec),
        .new_flags_i (new_flags),
        .hit_o       (stat_hit_o),
        .flags_o     (cur_flags)
    );

    // Debug requests win over the external interrupt at the same boundary
    assign irq_d = bnd_valid_i && ext_irq_i && !req_d.fault && !req_d.trap;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            irq_q <= 1'b0;
        end else begin
            req_q <= req_d;
            irq_q <= irq_d;
        end
    end

    assign fault_req_o = req_q.fault;
    assign trap_req_o  = req_q.trap;
    assign irq_take_o  = irq_q;
    assign stat_step_o = cur_flags.step;
    assign stat_prot_o = cur_flags.prot;
    assign stat_task_o = cur_flags.tsw;
    assign stall_o     = data_busy_i && exact_on(exact_en_i);

    // R1: requests only follow a boundary strobe
    assert_fault_after_bnd_R1: assert property (@(posedge clk) disable iff (rst)
        fault_req_o |-> $past(bnd_valid_i));
    assert_trap_after_bnd_R8: assert property (@(posedge clk) disable iff (rst)
        trap_req_o |-> $past(bnd_valid_i));

    // R2: restart flag masks instruction-address faults
    assert_restart_masks_R2: assert property (@(posedge clk) disable iff (rst)
        (bnd_valid_i && restart_i && !(dreg_access_i && emu_own_i)) |=> !fault_req_o);

    // R3: protected access while emulator owns registers
    assert_prot_fault_R3: assert property (@(posedge clk) disable iff (rst)
        (bnd_valid_i && dreg_access_i && emu_own_i) |=> (fault_req_o && stat_prot_o));

    // R5: inexact data hits never request a trap on their own
    assert_inexact_no_trap_R5: assert property (@(posedge clk) disable iff (rst)
        (bnd_valid_i && exact_en_i == '0 && !trace_i && !task_trace_i) |=> !trap_req_o);

    // R6: single step always traps and records BS-style status
    assert_step_trap_R6: assert property (@(posedge clk) disable iff (rst)
        (bnd_valid_i && trace_i) |=> (trap_req_o && stat_step_o));

    // R10: stall only with an exact enable
    assert_stall_needs_exact_R10: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> (exact_en_i != '0));

    // R11: interrupt never taken alongside a debug request
    assert_irq_yields_R11: assert property (@(posedge clk) disable iff (rst)
        irq_take_o |-> !(fault_req_o || trap_req_o));
endmodule

// File: tb/dbg_event_collector_tb_top.sv
`timescale 1ns/100ps
module dbg_event_collector_tb_top;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bnd_valid_i = 0;
    logic [NS-1:0] ia_hit_i = '0;
    logic [NS-1:0] da_hit_i = '0;
    logic [1:0]    exact_en_i = '0;
    logic          data_busy_i = 0, trace_i = 0, task_trace_i = 0;
    logic          dreg_access_i = 0, emu_own_i = 0, restart_i = 0;
    logic          ext_irq_i = 0, stat_clr_i = 0;
    logic          fault_req_o, trap_req_o, stat_step_o, stat_prot_o, stat_task_o;
    logic          stall_o, irq_take_o;
    logic [NS-1:0] stat_hit_o;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit done = 0;

    // reference model state
    int m_fault = 0, m_trap = 0, m_irq = 0, m_hit = 0, m_bs = 0, m_bd = 0, m_bt = 0;

    always #2.5 clk = ~clk;

    dbg_event_collector #(.N_SLOTS(NS)) dut_i (
        .clk(clk), .rst(rst), .bnd_valid_i(bnd_valid_i), .ia_hit_i(ia_hit_i),
        .da_hit_i(da_hit_i), .exact_en_i(exact_en_i), .data_busy_i(data_busy_i),
        .trace_i(trace_i), .task_trace_i(task_trace_i), .dreg_access_i(dreg_access_i),
        .emu_own_i(emu_own_i), .restart_i(restart_i), .ext_irq_i(ext_irq_i),
        .stat_clr_i(stat_clr_i), .fault_req_o(fault_req_o), .trap_req_o(trap_req_o),
        .stat_hit_o(stat_hit_o), .stat_step_o(stat_step_o), .stat_prot_o(stat_prot_o),
        .stat_task_o(stat_task_o), .stall_o(stall_o), .irq_take_o(irq_take_o)
    );

    // Behavioural model: what each boundary should produce, from the requirements
    always @(posedge clk) begin
        if (rst) begin
            m_fault = 0; m_trap = 0; m_irq = 0; m_hit = 0; m_bs = 0; m_bd = 0; m_bt = 0;
        end else begin
            int ia_eff, f, t, new_hit;
            ia_eff  = (bnd_valid_i && !restart_i) ? int'(ia_hit_i) : 0;
            f = (ia_eff != 0) || (bnd_valid_i && dreg_access_i && emu_own_i);
            t = (bnd_valid_i && da_hit_i != 0 && exact_en_i != 0) ||
                (bnd_valid_i && trace_i) || (bnd_valid_i && task_trace_i);
            new_hit = ia_eff | (bnd_valid_i ? int'(da_hit_i) : 0);
            if (stat_clr_i) begin m_hit = 0; m_bs = 0; m_bd = 0; m_bt = 0; end
            m_hit = m_hit | new_hit;
            if (bnd_valid_i && trace_i) m_bs = 1;
            if (bnd_valid_i && dreg_access_i && emu_own_i) m_bd = 1;
            if (bnd_valid_i && task_trace_i) m_bt = 1;
            m_irq   = bnd_valid_i && ext_irq_i && !f && !t;
            m_fault = f;
            m_trap  = t;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every clock, away from the rising edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R1/R2/R3 fault_req", int'(fault_req_o), m_fault);
            chk("R4/R6/R7 trap_req", int'(trap_req_o), m_trap);
            chk("R9 stat_hit", int'(stat_hit_o), m_hit);
            chk("R6 stat_step", int'(stat_step_o), m_bs);
            chk("R3 stat_prot", int'(stat_prot_o), m_bd);
            chk("R7 stat_task", int'(stat_task_o), m_bt);
            chk("R11 irq_take", int'(irq_take_o), m_irq);
            chk("R10 stall", int'(stall_o), int'(data_busy_i && exact_en_i != 0));
        end
    end

    task automatic idle();
        bnd_valid_i = 0; ia_hit_i = '0; da_hit_i = '0; trace_i = 0; task_trace_i = 0;
        dreg_access_i = 0; restart_i = 0; ext_irq_i = 0; stat_clr_i = 0; data_busy_i = 0;
    endtask

    task automatic nxt();
        @(negedge clk); #1;
        idle();
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(5 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk("R12 fault reset", int'(fault_req_o), 0);
        chk("R12 trap reset", int'(trap_req_o), 0);
        chk("R12 status reset", int'({stat_hit_o, stat_step_o, stat_prot_o, stat_task_o}), 0);
        chk("R12 irq reset", int'(irq_take_o), 0);
        #1 rst = 0;
        cmp_on = 1;

        // R1: each slot alone, then all together
        for (int s = 0; s < NS; s++) begin
            nxt(); bnd_valid_i = 1; ia_hit_i = NS'(1 << s);
            nxt(); stat_clr_i = 1;
        end
        nxt(); bnd_valid_i = 1; ia_hit_i = '1;
        // R1: hit without boundary strobe does nothing
        nxt(); ia_hit_i = '1;
        nxt(); stat_clr_i = 1;
        // R2: restart masks address fault, not data/step
        nxt(); bnd_valid_i = 1; restart_i = 1; ia_hit_i = 4'b0011; da_hit_i = 4'b1000;
               exact_en_i = 2'b01; trace_i = 1;
        nxt(); stat_clr_i = 1;
        // R3: protected access, with and without ownership
        nxt(); bnd_valid_i = 1; dreg_access_i = 1; emu_own_i = 1;
        nxt(); bnd_valid_i = 1; dreg_access_i = 1; emu_own_i = 0;
        nxt(); stat_clr_i = 1;
        // R4 / R5: exact enables in each combination
        for (int e = 0; e < 4; e++) begin
            nxt(); bnd_valid_i = 1; exact_en_i = 2'(e); da_hit_i = 4'b0100;
            nxt(); stat_clr_i = 1;
        end
        // R7: task-switch trap; R8: fault and trap together
        nxt(); bnd_valid_i = 1; task_trace_i = 1;
        nxt(); bnd_valid_i = 1; ia_hit_i = 4'b0001; trace_i = 1; exact_en_i = 2'b10;
               da_hit_i = 4'b0010; dreg_access_i = 1; emu_own_i = 1;
        // R9: sticky accumulation, then clear on a boundary cycle
        nxt(); bnd_valid_i = 1; ia_hit_i = 4'b1000;
        nxt();
        nxt(); stat_clr_i = 1; bnd_valid_i = 1; da_hit_i = 4'b0100;
        nxt(); stat_clr_i = 1;
        // R10: stall with and without an enable
        nxt(); data_busy_i = 1; exact_en_i = 2'b00;
        nxt(); data_busy_i = 1; exact_en_i = 2'b11;
        // R11: interrupt with single step first, then alone
        nxt(); bnd_valid_i = 1; ext_irq_i = 1; trace_i = 1;
        nxt(); bnd_valid_i = 1; ext_irq_i = 1;
        nxt(); ext_irq_i = 1;
        nxt(); stat_clr_i = 1;

        // Biased random traffic across all requirements
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); #1;
            bnd_valid_i   = ($urandom_range(0, 2) != 0);
            ia_hit_i      = ($urandom_range(0, 3) == 0) ? NS'($urandom) : '0;
            da_hit_i      = ($urandom_range(0, 3) == 0) ? NS'($urandom) : '0;
            exact_en_i    = 2'($urandom);
            data_busy_i   = 1'($urandom);
            trace_i       = ($urandom_range(0, 5) == 0);
            task_trace_i  = ($urandom_range(0, 9) == 0);
            dreg_access_i = ($urandom_range(0, 5) == 0);
            emu_own_i     = 1'($urandom);
            restart_i     = ($urandom_range(0, 3) == 0);
            ext_irq_i     = ($urandom_range(0, 2) == 0);
            stat_clr_i    = ($urandom_range(0, 7) == 0);
        end
        nxt();
        nxt();
        finish_run();
    end
endmodule